// File: doc/BRIEF.md
# Eight-bit timer/counter with assignable prescaler

The block is an eight-bit up-counter that a processor core reads and loads over a plain register port. It counts one of two sources. The first is the core clock, where one clock is one instruction cycle. The second is transitions on an external input pin, with a choice of rising or falling edges. The pin is resynchronised before its edges are detected.

A single eight-bit prescaler divides events by a power of two. It can serve the counter, or it can be lent to a watchdog tick path, but never both at once. While the watchdog owns the prescaler, the counter runs undivided. While the counter owns it, the watchdog tick passes through undivided. An eight-bit option word, loaded in one write, selects the source, the edge, the owner of the prescaler and the ratio.

A load of the count register freezes counting for a short window, so that software sees a predictable value. The counter raises a one-cycle pulse each time it wraps from FFh to 00h.

Top module: `tmr_prescaled_counter`

## Requirements
- R1: After reset the count reads 00h, ovf_pulse and dog_tick are low, and all eight option bits are 1. In that state the counter follows falling edges of the pin without division, and the watchdog tick is divided by 128.
- R2: With option bit 7 = 0 the count advances by one on every clock outside the hold window. With bit 5 = 1 the ratio field has no influence on that rate.
- R3: With option bit 7 = 1 the count follows pin edges: rising when bit 6 = 0, falling when bit 6 = 1. Each qualifying edge is counted once. The change shows at the third clock edge after the pin moves, because of a two-flop synchroniser and one edge-history flop. Edges of the other polarity are ignored.
- R4: With option bit 5 = 0 the count advances once per 2^(N+1) source events, where N is option bits 2:0. This gives ratios from 1:2 to 1:256.
- R5: A count write shows the written value after its clock edge. The count does not advance on the next two clocks. Source events in the write cycle and in those two cycles are dropped. With bit 5 = 0 the prescaler restarts from zero.
- R6: ovf_pulse is high for exactly the one cycle in which the count first reads 00h after an increment from FFh. A write never raises it.
- R7: With option bit 5 = 1, dog_tick pulses one clock after every 2^N-th dog_src pulse, giving 1:1 to 1:128. With bit 5 = 0, dog_tick repeats dog_src one clock later.
- R8: An option write restarts the prescaler from zero. Option bits 4:3 have no effect.
- R9: A count write that coincides with an increment loads the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one instruction cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Load strobe for the option word |
| opt_wdata | input | 8 | Option word: bit 7 source, bit 6 edge, bit 5 prescaler owner, bits 2:0 ratio |
| cnt_we | input | 1 | Load strobe for the count register |
| cnt_wdata | input | CNT_W | Value loaded into the count register |
| cnt_rdata | output | CNT_W | Current count |
| ext_clk_pin | input | 1 | External count pin, asynchronous |
| dog_src | input | 1 | Raw watchdog tick, one clock wide |
| dog_tick | output | 1 | Watchdog tick after optional division |
| ovf_pulse | output | 1 | One-cycle wrap indication |

## Verification
A prescaler that is not cleared shows up as an increment that arrives early. The count changes a fixed number of events too soon after a count or option write, and the first period after the write makes this visible. A wrong hold counter shows within three cycles of a load, as a count that moves during the hold window or stays frozen past it. A wrong synchroniser depth or edge history moves the external-edge increment away from the third clock, or counts the wrong polarity. A wrong mask in the divider misplaces a watchdog tick or a timer step. The scoreboard ties each expected value to an absolute cycle number, so any such shift is caught at the first affected cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int OPT_W        = 8;
   localparam int RATIO_W      = 3;
   localparam int OPT_SRC_BIT  = 7;
   localparam int OPT_EDGE_BIT = 6;
   localparam int OPT_OWN_BIT  = 5;

   typedef struct packed {
      logic               src_ext;
      logic               fall_edge;
      logic               pre_to_dog;
      logic [RATIO_W-1:0] ratio;
   } tmr_opt_t;

   function automatic tmr_opt_t opt_decode(input logic [OPT_W-1:0] w);
      tmr_opt_t o;
      o.src_ext    = w[OPT_SRC_BIT];
      o.fall_edge  = w[OPT_EDGE_BIT];
      o.pre_to_dog = w[OPT_OWN_BIT];
      o.ratio      = w[RATIO_W-1:0];
      return o;
   endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_pulse
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its history
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign edge_pulse = fall_sel ? (sh_q[STAGES] & ~sh_q[STAGES-1])
                                : (sh_q[STAGES-1] & ~sh_q[STAGES]);

   // R3: a single transition yields a single pulse
   assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |=> (!edge_pulse || (fall_sel != $past(fall_sel))));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W   = 8,
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               ev,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               extra,
   output logic               hit
);
   generate
      if (PRE_W < (1 << RATIO_W)) begin : g_bad_width
         $error("tmr_prescaler: PRE_W too small for the ratio field");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;
   logic [RATIO_W:0] shamt;

   assign shamt = {1'b0, ratio} + {{RATIO_W{1'b0}}, extra};

   generate
      for (genvar g = 0; g < PRE_W; g++) begin : g_mask
         assign mask[g] = (g < int'(shamt));
      end
   endgenerate

   assign hit = ev & ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else if (ev)  pre_q <= pre_q + PRE_W'(1);
   end

   // R4: the divider state moves only on a source event or a restart
   assert_pre_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev && !clr) |=> $stable(pre_q));
   // R8: a restart leaves the divider at zero
   assert_pre_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre_q == '0));
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
   parameter int WIDTH = 8,
   parameter int HOLD  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   input  logic             inc,
   output logic [WIDTH-1:0] cnt_q,
   output logic             ovf_q,
   output logic             busy
);
   localparam int HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("tmr_count_reg: HOLD must be at least 1");
      end
   endgenerate

   logic [HW-1:0] hold_q;
   logic          step;

   assign busy = we | (hold_q != '0);
   assign step = inc & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
         hold_q <= '0;
      end else begin
         ovf_q <= step & (cnt_q == '1);
         if (we) begin
            cnt_q  <= wdata;
            hold_q <= HOLD_V;
         end else begin
            if (hold_q != '0) hold_q <= hold_q - HW'(1);
            if (step)         cnt_q  <= cnt_q + WIDTH'(1);
         end
      end
   end

   // checker-only: cycles elapsed since the last load, saturating at HOLD
   logic [HW-1:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_q <= HOLD_V;
      else if (we)             since_q <= '0;
      else if (since_q < HOLD_V) since_q <= since_q + HW'(1);
   end

   // R9: the written value lands unchanged
   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (cnt_q == $past(wdata)));
   // R5: no movement inside the hold window
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_q < HOLD_V) && !we) |=> $stable(cnt_q));
   // R2: without a load the count moves by at most one
   assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + WIDTH'(1))));
   // R6: the wrap pulse coincides with a zero count reached without a load
   assert_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> ((cnt_q == '0) && !$past(we)));
endmodule

// File: rtl/tmr_prescaled_counter.sv
module tmr_prescaled_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opt_we,
   input  logic [OPT_W-1:0] opt_wdata,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt_rdata,
   input  logic             ext_clk_pin,
   input  logic             dog_src,
   output logic             dog_tick,
   output logic             ovf_pulse
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("tmr_prescaled_counter: CNT_W must be at least 2");
      end
   endgenerate

   tmr_opt_t opt_q;
   logic     pin_edge, src_ev, tmr_ev, busy;
   logic     pre_ev, pre_clr, pre_hit, cnt_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      opt_q <= '1;
      else if (opt_we) opt_q <= opt_decode(opt_wdata);
   end

   tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin),
      .fall_sel(opt_q.fall_edge), .edge_pulse(pin_edge));

   assign src_ev  = opt_q.src_ext ? pin_edge : 1'b1;
   assign tmr_ev  = src_ev & ~busy;
   assign pre_ev  = opt_q.pre_to_dog ? dog_src : tmr_ev;
   assign pre_clr = opt_we | (cnt_we & ~opt_q.pre_to_dog);
   assign cnt_inc = opt_q.pre_to_dog ? tmr_ev : pre_hit;

   tmr_prescaler #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(pre_clr), .ev(pre_ev),
      .ratio(opt_q.ratio), .extra(~opt_q.pre_to_dog), .hit(pre_hit));

   tmr_count_reg #(.WIDTH(CNT_W), .HOLD(HOLD_CYC)) u_cnt (
      .clk(clk), .rst_n(rst_n), .we(cnt_we), .wdata(cnt_wdata),
      .inc(cnt_inc), .cnt_q(cnt_rdata), .ovf_q(ovf_pulse), .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dog_tick <= 1'b0;
      else        dog_tick <= opt_q.pre_to_dog ? pre_hit : dog_src;
   end

   // R7: undivided watchdog path while the counter owns the prescaler
   assert_dog_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_q.pre_to_dog |=> (dog_tick == $past(dog_src)));
   // R2: clock source with the prescaler lent away counts every free cycle
   assert_clk_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!opt_q.src_ext && opt_q.pre_to_dog && !busy)
         |=> (cnt_rdata == $past(cnt_rdata) + CNT_W'(1)));
endmodule

// File: tb/tmr_prescaled_counter_test.sv
`timescale 1ns/1ps
module tmr_prescaled_counter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       opt_we = 1'b0;
   logic [7:0] opt_wdata = '0;
   logic       cnt_we = 1'b0;
   logic [7:0] cnt_wdata = '0;
   logic [7:0] cnt_rdata;
   logic       ext_clk_pin = 1'b0;
   logic       dog_src = 1'b0;
   logic       dog_tick;
   logic       ovf_pulse;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int    due;
      int    kind;   // 0 count, 1 wrap pulse, 2 watchdog tick
      int    val;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;                 // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   tmr_prescaled_counter uut (
      .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
      .ext_clk_pin(ext_clk_pin), .dog_src(dog_src), .dog_tick(dog_tick),
      .ovf_pulse(ovf_pulse));

   // monitor: compare every item that falls due at this sampling point
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin : cmp
            int act;
            act = (sb[i].kind == 0) ? int'(cnt_rdata) :
                  (sb[i].kind == 1) ? int'(ovf_pulse) : int'(dog_tick);
            n_chk++;
            if (act != sb[i].val) begin
               n_fail++;
               $display("FAIL %s: actual %0h expected %0h (cycle %0d)",
                        sb[i].tag, act, sb[i].val, cyc);
            end
            sb.delete(i);
         end
      end
   end

   task automatic expect_at(input int due, input int kind, input int val, input string tag);
      exp_t e;
      e.due = due; e.kind = kind; e.val = val; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_opt(input logic [7:0] v);
      opt_we = 1'b1; opt_wdata = v;
      tick();
      opt_we = 1'b0;
   endtask

   task automatic wr_cnt(input logic [7:0] v);
      cnt_we = 1'b1; cnt_wdata = v;
      tick();
      cnt_we = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      int c;
      tick(4);
      rst_n = 1'b1;
      c = cyc;
      expect_at(c + 1, 0, 8'h00, "R1 reset count");
      expect_at(c + 1, 1, 0, "R1 reset wrap pulse");
      expect_at(c + 1, 2, 0, "R1 reset watchdog tick");
      tick();

      // R1/R3 default option: falling pin edges, rising ignored
      c = cyc; ext_clk_pin = 1'b1;
      expect_at(c + 3, 0, 8'h00, "R3 rising edge ignored in falling mode");
      expect_at(c + 4, 0, 8'h00, "R3 rising edge ignored in falling mode");
      tick(5);
      c = cyc; ext_clk_pin = 1'b0;
      expect_at(c + 2, 0, 8'h00, "R3 synchroniser latency");
      expect_at(c + 3, 0, 8'h01, "R1 falling edge counted by default");
      tick(4);

      // R1/R7 default watchdog division 1:128
      for (int i = 1; i <= 128; i++) begin
         c = cyc; dog_src = 1'b1;
         expect_at(c + 1, 2, (i == 128) ? 1 : 0, "R7 default watchdog 1:128 (R1)");
         tick(); dog_src = 1'b0; tick();
      end

      // R2: clock source, prescaler on watchdog with ratio 7, counter 1:1
      wr_opt(8'h27);
      tick(3);
      c = cyc;
      expect_at(c + 1, 0, 8'hFD, "R5 load value");
      expect_at(c + 2, 0, 8'hFD, "R5 hold cycle 1");
      expect_at(c + 3, 0, 8'hFD, "R5 hold cycle 2");
      expect_at(c + 4, 0, 8'hFE, "R2 clock count 1:1");
      expect_at(c + 5, 0, 8'hFF, "R2 clock count 1:1");
      expect_at(c + 5, 1, 0, "R6 no wrap before 00");
      expect_at(c + 6, 0, 8'h00, "R6 wrap to 00");
      expect_at(c + 6, 1, 1, "R6 wrap pulse");
      expect_at(c + 7, 1, 0, "R6 wrap pulse one cycle");
      expect_at(c + 7, 0, 8'h01, "R2 count after wrap");
      wr_cnt(8'hFD);
      tick(7);

      // R9: write while counting wins; R6: loading 00 raises no pulse
      c = cyc;
      expect_at(c + 1, 0, 8'h40, "R9 write beats increment");
      expect_at(c + 4, 0, 8'h41, "R9 count resumes after hold");
      wr_cnt(8'h40);
      tick(3);
      c = cyc;
      expect_at(c + 1, 0, 8'hFF, "R5 load FF");
      expect_at(c + 3, 0, 8'h00, "R9 second write in hold");
      expect_at(c + 3, 1, 0, "R6 write of 00 gives no pulse");
      expect_at(c + 4, 1, 0, "R6 write of 00 gives no pulse");
      expect_at(c + 5, 0, 8'h00, "R5 hold restarted by write");
      expect_at(c + 6, 0, 8'h01, "R5 count resumes");
      expect_at(c + 6, 1, 0, "R6 no pulse on 00 to 01");
      wr_cnt(8'hFF);
      tick();
      wr_cnt(8'h00);
      tick(5);

      // R4: clock source through prescaler 1:4
      wr_opt(8'h01);
      c = cyc;
      expect_at(c + 6, 0, 8'h10, "R4 1:4 not yet");
      expect_at(c + 7, 0, 8'h11, "R4 1:4 first step");
      expect_at(c + 10, 0, 8'h11, "R4 1:4 between steps");
      expect_at(c + 11, 0, 8'h12, "R4 1:4 second step");
      wr_cnt(8'h10);
      tick(12);

      // R4: ratio 7 gives 1:256
      wr_opt(8'h07);
      c = cyc;
      expect_at(c + 258, 0, 8'h00, "R4 1:256 not yet");
      expect_at(c + 259, 0, 8'h01, "R4 1:256 step");
      wr_cnt(8'h00);
      tick(260);

      // R8: option write restarts prescaler, bits 4:3 ignored
      wr_opt(8'h01);
      c = cyc;
      expect_at(c + 7, 0, 8'h50, "R8 prescaler restarted by option write");
      expect_at(c + 9, 0, 8'h50, "R8 prescaler restarted by option write");
      expect_at(c + 10, 0, 8'h51, "R8 ratio unchanged by bits 4:3");
      wr_cnt(8'h50);
      tick(4);
      wr_opt(8'h19);
      tick(6);

      // R3 rising edges with prescaler 1:2; R5 write restarts prescaler
      wr_opt(8'h80);
      wr_cnt(8'h00);
      tick(5);
      c = cyc; ext_clk_pin = 1'b1;
      expect_at(c + 4, 0, 8'h00, "R4 1:2 first edge held in prescaler");
      tick(4); ext_clk_pin = 1'b0;
      tick(4);
      c = cyc; ext_clk_pin = 1'b1;
      expect_at(c + 2, 0, 8'h00, "R3 rising latency");
      expect_at(c + 3, 0, 8'h01, "R3 rising edge counted");
      tick(4); ext_clk_pin = 1'b0;
      expect_at(cyc + 4, 0, 8'h01, "R3 falling edge ignored in rising mode");
      tick(4);
      c = cyc; ext_clk_pin = 1'b1;
      expect_at(c + 4, 0, 8'h01, "R4 odd edge held in prescaler");
      tick(4); ext_clk_pin = 1'b0;
      tick(4);
      c = cyc;
      expect_at(c + 1, 0, 8'h20, "R5 load in edge mode");
      wr_cnt(8'h20);
      tick(4);
      c = cyc; ext_clk_pin = 1'b1;
      expect_at(c + 4, 0, 8'h20, "R5 prescaler restarted by count write");
      tick(4); ext_clk_pin = 1'b0;
      tick(4);
      c = cyc; ext_clk_pin = 1'b1;
      expect_at(c + 2, 0, 8'h20, "R3 latency second edge");
      expect_at(c + 3, 0, 8'h21, "R5 step after restarted prescaler");
      tick(5); ext_clk_pin = 1'b0;
      tick(2);

      // R7: bypass while counter owns prescaler
      c = cyc; dog_src = 1'b1;
      expect_at(c + 1, 2, 1, "R7 bypass tick");
      expect_at(c + 2, 2, 0, "R7 bypass tick ends");
      tick(); dog_src = 1'b0; tick(2);

      // R7: watchdog division 1:4
      wr_opt(8'h22);
      for (int i = 1; i <= 4; i++) begin
         c = cyc; dog_src = 1'b1;
         expect_at(c + 1, 2, (i == 4) ? 1 : 0, "R7 watchdog 1:4");
         tick(); dog_src = 1'b0; tick();
      end
      tick(3);

      foreach (sb[i]) begin
         n_chk++; n_fail++;
         $display("FAIL %s: actual unchecked expected check at cycle %0d", sb[i].tag, sb[i].due);
      end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule